// File: doc/BRIEF.md
# Reorder-Buffer Tagged Register Alias Table

This block is the rename map of an out-of-order core that keeps results in a reorder buffer. It holds one entry per architectural register. Each entry says where the newest value of that register lives: either in the architectural register file, or in a specific reorder buffer slot that will receive it. Operand lookups return that location, so the operand can be read from the register file or waited on by buffer index.

The block has four sources of updates. Issue points a destination register at its newly allocated buffer slot. Retirement moves a register back to the register file, but only if no younger instruction has renamed it in the meantime. A mispredict flush sends every register back to the register file in a single cycle. A result broadcast has no port here: the value arrives in the buffer slot the entry already names, so the map does not change.

Register 0 is hardwired. It is never renamed and always reads as ready in the register file. The value storage and the register file themselves live outside this block.

Top module: `rob_alias_table`

## Requirements
- R1: After reset, every register looks up as ready in the register file: busy 0 and tag 0.
- R2: An issue with `iss_valid_i` high to a nonzero `iss_rd_i` makes that register look up as busy, with tag `iss_tag_i`, starting in the next cycle.
- R3: Source lookups are combinational. In the cycle of an issue, they show the map state before that issue is applied.
- R4: A lookup returns busy 1 together with the stored buffer index. Otherwise it returns busy 0 and tag 0.
- R5: A commit (`cmt_valid_i`) whose `cmt_tag_i` equals the tag held by busy register `cmt_rd_i` frees that register from the next cycle.
- R6: A commit whose tag differs from the held tag, or that targets a free register, leaves that entry unchanged.
- R7: When an issue and a commit name the same register in one cycle, the issue result is what the register holds afterwards.
- R8: `flush_i` frees every register in the next cycle. An issue in the same cycle as a flush is discarded.
- R9: Register 0 is never renamed and always looks up as busy 0 and tag 0, even after an issue to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Rename a destination this cycle |
| iss_rd_i | input | $clog2(NREG) | Destination register being renamed |
| iss_tag_i | input | $clog2(NROB) | Newly allocated buffer index |
| src0_reg_i | input | $clog2(NREG) | First operand register |
| src0_busy_o | output | 1 | First operand is pending in the buffer |
| src0_tag_o | output | $clog2(NROB) | Buffer index of the first operand, 0 if ready |
| src1_reg_i | input | $clog2(NREG) | Second operand register |
| src1_busy_o | output | 1 | Second operand is pending in the buffer |
| src1_tag_o | output | $clog2(NROB) | Buffer index of the second operand, 0 if ready |
| cmt_valid_i | input | 1 | Retire a result this cycle |
| cmt_rd_i | input | $clog2(NREG) | Register being retired |
| cmt_tag_i | input | $clog2(NROB) | Buffer index being retired |
| flush_i | input | 1 | Mispredict flush: free all registers |

## Verification
The assertions check the following on every cycle:
- the issue update;
- the flush clear;
- the tag-matched retirement and its mismatch case;
- issue priority over commit;
- the zeroed tag on a ready lookup;
- the hardwired register 0.

Two behaviours show up only in the bench's scenarios. The first is that a lookup sees the state from before the issue in the same cycle. The second is the older-commit-after-younger-rename ordering. The bench covers both through directed sequences and a long random mix. In that mix, a behavioural model of the map is compared with both lookup ports on every cycle.

// File: rtl/rat_pkg.sv
package rat_pkg;
  parameter int unsigned DEF_NREG = 32;
  parameter int unsigned DEF_NROB = 16;
endpackage

// File: rtl/rat_entry.sv
module rat_entry #(
  parameter int unsigned TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          iss_hit_i,
  input  logic [TW-1:0] iss_tag_i,
  input  logic          cmt_hit_i,
  input  logic [TW-1:0] cmt_tag_i,
  output logic          busy_o,
  output logic [TW-1:0] tag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      tag_o  <= '0;
    end else if (flush_i) begin
      busy_o <= 1'b0;
    end else if (iss_hit_i) begin
      busy_o <= 1'b1;
      tag_o  <= iss_tag_i;
    end else if (cmt_hit_i && busy_o && (tag_o == cmt_tag_i)) begin
      // only the youngest mapping is released
      busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rat_lookup.sv
module rat_lookup #(
  parameter int unsigned NREG = 32,
  parameter int unsigned TW   = 4,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic [NREG-1:0]         busy_i,
  input  logic [NREG-1:0][TW-1:0] tag_i,
  input  logic [AW-1:0]           reg_i,
  output logic                    busy_o,
  output logic [TW-1:0]           tag_o
);
  assign busy_o = busy_i[reg_i];
  assign tag_o  = busy_o ? tag_i[reg_i] : '0;
endmodule

// File: rtl/rob_alias_table.sv
module rob_alias_table #(
  parameter int unsigned NREG = rat_pkg::DEF_NREG,
  parameter int unsigned NROB = rat_pkg::DEF_NROB,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned TW  = $clog2(NROB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          iss_valid_i,
  input  logic [AW-1:0] iss_rd_i,
  input  logic [TW-1:0] iss_tag_i,
  input  logic [AW-1:0] src0_reg_i,
  output logic          src0_busy_o,
  output logic [TW-1:0] src0_tag_o,
  input  logic [AW-1:0] src1_reg_i,
  output logic          src1_busy_o,
  output logic [TW-1:0] src1_tag_o,
  input  logic          cmt_valid_i,
  input  logic [AW-1:0] cmt_rd_i,
  input  logic [TW-1:0] cmt_tag_i,
  input  logic          flush_i
);
  logic [NREG-1:0]         busy_q;
  logic [NREG-1:0][TW-1:0] tag_q;

  // register 0 is constant and never renamed
  assign busy_q[0] = 1'b0;
  assign tag_q[0]  = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_ent
    logic iss_hit, cmt_hit;
    assign iss_hit = iss_valid_i && (iss_rd_i == AW'(g));
    assign cmt_hit = cmt_valid_i && (cmt_rd_i == AW'(g));
    rat_entry #(.TW(TW)) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (flush_i),
      .iss_hit_i (iss_hit),
      .iss_tag_i (iss_tag_i),
      .cmt_hit_i (cmt_hit),
      .cmt_tag_i (cmt_tag_i),
      .busy_o    (busy_q[g]),
      .tag_o     (tag_q[g])
    );
  end

  rat_lookup #(.NREG(NREG), .TW(TW)) u_src0 (
    .busy_i (busy_q),
    .tag_i  (tag_q),
    .reg_i  (src0_reg_i),
    .busy_o (src0_busy_o),
    .tag_o  (src0_tag_o)
  );

  rat_lookup #(.NREG(NREG), .TW(TW)) u_src1 (
    .busy_i (busy_q),
    .tag_i  (tag_q),
    .reg_i  (src1_reg_i),
    .busy_o (src1_busy_o),
    .tag_o  (src1_tag_o)
  );
endmodule

// File: rtl/rat_checker.sv
module rat_checker #(
  parameter int unsigned NREG = 32,
  parameter int unsigned NROB = 16,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned TW  = $clog2(NROB)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    iss_valid_i,
  input logic [AW-1:0]           iss_rd_i,
  input logic [TW-1:0]           iss_tag_i,
  input logic [AW-1:0]           src0_reg_i,
  input logic                    src0_busy_o,
  input logic [TW-1:0]           src0_tag_o,
  input logic                    cmt_valid_i,
  input logic [AW-1:0]           cmt_rd_i,
  input logic [TW-1:0]           cmt_tag_i,
  input logic                    flush_i,
  input logic [NREG-1:0]         busy_q,
  input logic [NREG-1:0][TW-1:0] tag_q
);
  logic same_rd;
  assign same_rd = iss_valid_i && (iss_rd_i == cmt_rd_i);

  assert_issue_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i && !flush_i && iss_rd_i != '0) |=>
      (busy_q[$past(iss_rd_i)] && tag_q[$past(iss_rd_i)] == $past(iss_tag_i)));

  assert_free_tag_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src0_busy_o |-> (src0_tag_o == '0));

  assert_commit_frees_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_valid_i && !flush_i && !same_rd && busy_q[cmt_rd_i] && tag_q[cmt_rd_i] == cmt_tag_i)
      |=> !busy_q[$past(cmt_rd_i)]);

  assert_commit_mismatch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_valid_i && !flush_i && !same_rd && !(busy_q[cmt_rd_i] && tag_q[cmt_rd_i] == cmt_tag_i))
      |=> (busy_q[$past(cmt_rd_i)] == $past(busy_q[cmt_rd_i]) &&
           (!busy_q[$past(cmt_rd_i)] || tag_q[$past(cmt_rd_i)] == $past(tag_q[cmt_rd_i]))));

  assert_issue_beats_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_rd && cmt_valid_i && !flush_i && iss_rd_i != '0) |=> busy_q[$past(iss_rd_i)]);

  assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (busy_q == '0));

  assert_reg0_free_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src0_reg_i == '0) |-> (!src0_busy_o && src0_tag_o == '0));
endmodule

bind rob_alias_table rat_checker #(.NREG(NREG), .NROB(NROB)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iss_valid_i (iss_valid_i),
  .iss_rd_i    (iss_rd_i),
  .iss_tag_i   (iss_tag_i),
  .src0_reg_i  (src0_reg_i),
  .src0_busy_o (src0_busy_o),
  .src0_tag_o  (src0_tag_o),
  .cmt_valid_i (cmt_valid_i),
  .cmt_rd_i    (cmt_rd_i),
  .cmt_tag_i   (cmt_tag_i),
  .flush_i     (flush_i),
  .busy_q      (busy_q),
  .tag_q       (tag_q)
);

// File: tb/tb_rob_alias_table.sv
module tb_rob_alias_table;
  localparam int NREG = 32;
  localparam int NROB = 16;
  localparam int AW = $clog2(NREG);
  localparam int TW = $clog2(NROB);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic iss_valid_i = 0, cmt_valid_i = 0, flush_i = 0;
  logic [AW-1:0] iss_rd_i = '0, cmt_rd_i = '0, src0_reg_i = '0, src1_reg_i = '0;
  logic [TW-1:0] iss_tag_i = '0, cmt_tag_i = '0;
  logic src0_busy_o, src1_busy_o;
  logic [TW-1:0] src0_tag_o, src1_tag_o;

  always #2 clk = ~clk;

  rob_alias_table #(.NREG(NREG), .NROB(NROB)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .iss_valid_i(iss_valid_i), .iss_rd_i(iss_rd_i), .iss_tag_i(iss_tag_i),
    .src0_reg_i(src0_reg_i), .src0_busy_o(src0_busy_o), .src0_tag_o(src0_tag_o),
    .src1_reg_i(src1_reg_i), .src1_busy_o(src1_busy_o), .src1_tag_o(src1_tag_o),
    .cmt_valid_i(cmt_valid_i), .cmt_rd_i(cmt_rd_i), .cmt_tag_i(cmt_tag_i),
    .flush_i(flush_i)
  );

  bit m_busy[NREG];
  int m_tag[NREG];
  int errs = 0, checks = 0;
  bit done = 0;

  task automatic chk_one(string req, string port, int r, logic b, logic [TW-1:0] t);
    bit eb = m_busy[r];
    int et = eb ? m_tag[r] : 0;
    checks++;
    if (b !== eb || int'(t) != et) begin
      errs++;
      $display("FAIL %s %s reg=%0d got busy=%0b tag=%0d exp busy=%0b tag=%0d",
               req, port, r, b, t, eb, et);
    end
  endtask

  // behavioural reference update
  task automatic model_update();
    if (flush_i) begin
      foreach (m_busy[i]) m_busy[i] = 0;
    end else begin
      if (cmt_valid_i && m_busy[cmt_rd_i] && m_tag[cmt_rd_i] == int'(cmt_tag_i))
        m_busy[cmt_rd_i] = 0;
      if (iss_valid_i && iss_rd_i != 0) begin
        m_busy[iss_rd_i] = 1;
        m_tag[iss_rd_i] = int'(iss_tag_i);
      end
    end
  endtask

  task automatic cycle(string req);
    #1;
    chk_one(req, "src0", int'(src0_reg_i), src0_busy_o, src0_tag_o);
    chk_one(req, "src1", int'(src1_reg_i), src1_busy_o, src1_tag_o);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    iss_valid_i = 0; cmt_valid_i = 0; flush_i = 0;
  endtask

  task automatic issue(int r, int t);
    iss_valid_i = 1; iss_rd_i = AW'(r); iss_tag_i = TW'(t);
  endtask

  task automatic commit(int r, int t);
    cmt_valid_i = 1; cmt_rd_i = AW'(r); cmt_tag_i = TW'(t);
  endtask

  task automatic look(int a, int b);
    src0_reg_i = AW'(a); src1_reg_i = AW'(b);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    foreach (m_busy[i]) begin m_busy[i] = 0; m_tag[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    for (int r = 0; r < NREG; r++) begin look(r, NREG-1-r); cycle("R1"); end

    issue(5, 3); look(5, 5); cycle("R3");
    idle(); cycle("R2");
    commit(5, 7); cycle("R6");
    idle(); cycle("R6");
    issue(5, 9); cycle("R2");
    idle(); commit(5, 3); cycle("R6");
    idle(); cycle("R6");
    commit(5, 9); cycle("R5");
    idle(); cycle("R5");
    commit(5, 9); cycle("R6");
    idle(); issue(7, 2); look(7, 5); cycle("R2");
    idle(); issue(7, 4); commit(7, 2); cycle("R7");
    idle(); cycle("R7");
    issue(0, 5); look(0, 7); cycle("R9");
    idle(); cycle("R9");
    issue(10, 1); cycle("R2");
    issue(11, 6); look(10, 11); cycle("R2");
    idle(); cycle("R4");
    flush_i = 1; issue(12, 8); look(12, 7); cycle("R8");
    idle(); cycle("R8");
    for (int r = 0; r < NREG; r++) begin look(r, (r*7) % NREG); cycle("R8"); end

    for (int n = 0; n < 3000; n++) begin
      int cr;
      idle();
      if ($urandom % 2 == 0) issue(int'($urandom % NREG), int'($urandom % NROB));
      cr = int'($urandom % NREG);
      if ($urandom % 3 != 0)
        commit(cr, ($urandom % 10 < 7) ? m_tag[cr] : int'($urandom % NROB));
      flush_i = ($urandom % 40 == 0);
      look(int'($urandom % NREG), int'($urandom % NREG));
      cycle("R4");
    end

    idle();
    done = 1;
    summary();
    $finish;
  end
endmodule